// File: doc/BRIEF.md
# Posted-Store Queue with Fill Snooping

This block sits between a processor's data side and main memory and holds stores so the core does not wait for memory writes. Each store is parked in a small queue and handed to memory, oldest first, on a dedicated address and data pair. The memory side takes the entry by pulsing an acknowledge. The entry leaves the queue on that acknowledge and is never written again.

While a cache line is being refilled, the cache presents each word coming back from memory (address, data and a valid strobe) to the queue. If any held store targets that word, the queue returns its own newer data in place of the memory word, so a line refill cannot erase a store that has not reached memory yet. A typical case is a store to one word followed by a load miss on a neighbouring word of the same line. New stores are accepted in the same cycle as a refill word, because the refill stream carries its own address.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset, and whenever the queue is empty, `drain_valid_o` and `full_o` are low.
- R2: The oldest held store is shown on `drain_addr_o`/`drain_data_o` with `drain_valid_o` high. It stays unchanged until a cycle with `drain_ack_i` high. That edge removes it, and the next older-to-newer entry appears in the following cycle.
- R3: A store whose word address equals the entry currently offered to memory (the oldest) does not modify that entry. It takes a new slot.
- R4: A store whose word address equals any other held entry overwrites that entry's data and uses no new slot.
- R5: `full_o` is high exactly when all DEPTH (default 4) slots are occupied. A store seen at an edge while `full_o` is high is discarded unless it merges under R4, and a merging store is still accepted.
- R6: When `refill_valid_i` is high and `refill_addr_i` equals a held entry's address, `fill_hit_o` is high and `fill_data_o` carries that entry's data. Otherwise `fill_hit_o` is low and `fill_data_o` equals `refill_data_i`, including while `refill_valid_i` is low.
- R7: If more than one held entry matches the refill address, the most recently allocated one is forwarded.
- R8: Forwarding compares against the queue contents at the start of the cycle. A store arriving in the same cycle as a refill word is not forwarded for that word, but it is still captured.
- R9: An acknowledge and a new non-merging store in the same cycle retire one entry and add one, so the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request from the core |
| st_addr_i | input | 23 | Store word address |
| st_data_i | input | 32 | Store data |
| full_o | output | 1 | All slots occupied; core must hold further stores |
| drain_valid_o | output | 1 | An entry is offered to memory |
| drain_addr_o | output | 23 | Word address of the offered entry |
| drain_data_o | output | 32 | Data of the offered entry |
| drain_ack_i | input | 1 | Memory has taken the offered entry |
| refill_valid_i | input | 1 | A refill word from memory is present |
| refill_addr_i | input | 23 | Word address of the refill word |
| refill_data_i | input | 32 | Refill data from memory |
| fill_hit_o | output | 1 | Refill word replaced by a held store |
| fill_data_o | output | 32 | Word to be written into the cache |

## Verification
The hardest state to reach is two live entries with the same address, because merging normally removes duplicates. It arises only when a store targets the oldest entry while memory holds off its acknowledge. The stimulus builds this twice: once before a full-queue episode and once after the pointers have wrapped. It then sends refill words at that address to check that the younger data wins. The discarded-store case is also covered. The queue is filled, a store is sent to a fresh address, and a later refill word at that address must come back unchanged from memory.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned WB_ADDR_W = 23;
  localparam int unsigned WB_DATA_W = 32;
  localparam int unsigned WB_DEPTH  = 4;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 23,
  parameter int unsigned DW    = 32,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic [AW-1:0]             push_addr_i,
  input  logic [DW-1:0]             push_data_i,
  input  logic                      merge_i,
  input  logic [PW-1:0]             merge_idx_i,
  input  logic                      pop_i,
  output logic [DEPTH-1:0][AW-1:0]  addr_o,
  output logic [DEPTH-1:0][DW-1:0]  data_o,
  output logic [PW-1:0]             head_o,
  output logic [PW:0]               count_o
);
  logic [PW-1:0] tail_q, head_q;
  logic [PW:0]   count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      data_o  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) begin
        addr_o[tail_q] <= push_addr_i;
        data_o[tail_q] <= push_data_i;
        tail_q         <= tail_q + 1'b1;
      end
      // merge never targets the head slot, so it cannot race a drain
      if (merge_i) data_o[merge_idx_i] <= push_data_i;
      if (pop_i) head_q <= head_q + 1'b1;
      count_q <= count_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  assign head_o  = head_q;
  assign count_o = count_q;
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned AW        = 23,
  parameter int unsigned SKIP_HEAD = 0,
  localparam int unsigned PW       = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][AW-1:0] addr_i,
  input  logic [PW-1:0]            head_i,
  input  logic [PW:0]              count_i,
  input  logic                     en_i,
  input  logic [AW-1:0]            key_i,
  output logic                     hit_o,
  output logic [PW-1:0]            idx_o
);
  logic [PW-1:0] slot;

  // walk oldest to youngest; the last match wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = head_i;
    slot  = head_i;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_i + PW'(k);
      if (en_i && (k >= SKIP_HEAD) && ((PW+1)'(k) < count_i) && (addr_i[slot] == key_i)) begin
        hit_o = 1'b1;
        idx_o = slot;
      end
    end
  end
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = WB_DEPTH,
  parameter int unsigned AW    = WB_ADDR_W,
  parameter int unsigned DW    = WB_DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  output logic          full_o,
  output logic          drain_valid_o,
  output logic [AW-1:0] drain_addr_o,
  output logic [DW-1:0] drain_data_o,
  input  logic          drain_ack_i,
  input  logic          refill_valid_i,
  input  logic [AW-1:0] refill_addr_i,
  input  logic [DW-1:0] refill_data_i,
  output logic          fill_hit_o,
  output logic [DW-1:0] fill_data_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [PW-1:0]            head;
  logic [PW:0]              count;
  logic                     st_hit, push, merge, pop;
  logic [PW-1:0]            st_idx, fw_idx;

  assign full_o        = (count == (PW+1)'(DEPTH));
  assign drain_valid_o = (count != '0);
  assign drain_addr_o  = ent_addr[head];
  assign drain_data_o  = ent_data[head];

  assign merge = st_valid_i && st_hit;
  assign push  = st_valid_i && !st_hit && !full_o;
  assign pop   = drain_ack_i && drain_valid_o;

  wbuf_match #(.DEPTH(DEPTH), .AW(AW), .SKIP_HEAD(1)) u_st_match (
    .addr_i (ent_addr),
    .head_i (head),
    .count_i(count),
    .en_i   (st_valid_i),
    .key_i  (st_addr_i),
    .hit_o  (st_hit),
    .idx_o  (st_idx)
  );

  wbuf_match #(.DEPTH(DEPTH), .AW(AW), .SKIP_HEAD(0)) u_fw_match (
    .addr_i (ent_addr),
    .head_i (head),
    .count_i(count),
    .en_i   (refill_valid_i),
    .key_i  (refill_addr_i),
    .hit_o  (fill_hit_o),
    .idx_o  (fw_idx)
  );

  assign fill_data_o = fill_hit_o ? ent_data[fw_idx] : refill_data_i;

  wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_addr_i(st_addr_i),
    .push_data_i(st_data_i),
    .merge_i    (merge),
    .merge_idx_i(st_idx),
    .pop_i      (pop),
    .addr_o     (ent_addr),
    .data_o     (ent_data),
    .head_o     (head),
    .count_o    (count)
  );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int unsigned AW = 23,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_valid_i,
  input logic          full_o,
  input logic          drain_valid_o,
  input logic [AW-1:0] drain_addr_o,
  input logic [DW-1:0] drain_data_o,
  input logic          drain_ack_i,
  input logic          refill_valid_i,
  input logic [DW-1:0] refill_data_i,
  input logic          fill_hit_o,
  input logic [DW-1:0] fill_data_o
);
  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drain_valid_o && !st_valid_i |=> !drain_valid_o);

  // R2
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_valid_o && !drain_ack_i |=> drain_valid_o && $stable(drain_addr_o) && $stable(drain_data_o));

  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !drain_ack_i |=> full_o);

  // R5
  full_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> drain_valid_o);

  // R6
  hit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_hit_o |-> refill_valid_i && drain_valid_o);

  // R6
  fill_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_hit_o |-> fill_data_o == refill_data_i);
endmodule

bind wbuf_fwd wbuf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .st_valid_i    (st_valid_i),
  .full_o        (full_o),
  .drain_valid_o (drain_valid_o),
  .drain_addr_o  (drain_addr_o),
  .drain_data_o  (drain_data_o),
  .drain_ack_i   (drain_ack_i),
  .refill_valid_i(refill_valid_i),
  .refill_data_i (refill_data_i),
  .fill_hit_o    (fill_hit_o),
  .fill_data_o   (fill_data_o)
);

// File: tb/sim_wbuf_fwd.sv
module sim_wbuf_fwd;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_valid_i = 1'b0;
  logic [22:0] st_addr_i = '0;
  logic [31:0] st_data_i = '0;
  logic        drain_ack_i = 1'b0;
  logic        refill_valid_i = 1'b0;
  logic [22:0] refill_addr_i = '0;
  logic [31:0] refill_data_i = '0;
  logic        full_o, drain_valid_o, fill_hit_o;
  logic [22:0] drain_addr_o;
  logic [31:0] drain_data_o, fill_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wbuf_fwd u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_data_i(st_data_i),
    .full_o(full_o), .drain_valid_o(drain_valid_o),
    .drain_addr_o(drain_addr_o), .drain_data_o(drain_data_o), .drain_ack_i(drain_ack_i),
    .refill_valid_i(refill_valid_i), .refill_addr_i(refill_addr_i), .refill_data_i(refill_data_i),
    .fill_hit_o(fill_hit_o), .fill_data_o(fill_data_o)
  );

  typedef struct packed {
    logic        sv; logic [22:0] sa; logic [31:0] sd;
    logic        ak;
    logic        rv; logic [22:0] ra; logic [31:0] rd;
    logic        edv; logic [22:0] eda; logic [31:0] edd;
    logic        efull; logic ehit; logic [31:0] efd;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    // R1 empty after reset
    '{1'b0,23'h0,32'h0,    1'b0, 1'b0,23'h0,32'h0,   1'b0,23'h0,32'h0,    1'b0,1'b0,32'h0,  4'd1},
    // R8 store 10 same cycle as refill of 10: not forwarded
    '{1'b1,23'h10,32'h11,  1'b0, 1'b1,23'h10,32'hAA, 1'b0,23'h0,32'h0,    1'b0,1'b0,32'hAA, 4'd8},
    // R6 store 10 now forwarded
    '{1'b1,23'h20,32'h22,  1'b0, 1'b1,23'h10,32'h55, 1'b1,23'h10,32'h11,  1'b0,1'b1,32'h11, 4'd6},
    // R4 store 20 again merges (refill still sees old 22)
    '{1'b1,23'h20,32'h33,  1'b0, 1'b1,23'h20,32'h99, 1'b1,23'h10,32'h11,  1'b0,1'b1,32'h22, 4'd4},
    // R4 merged value visible; R3 store to head address 10 takes new slot
    '{1'b1,23'h10,32'h44,  1'b0, 1'b1,23'h20,32'h98, 1'b1,23'h10,32'h11,  1'b0,1'b1,32'h33, 4'd4},
    // R7 two entries at 10: younger 44 wins; R3 head still 11
    '{1'b1,23'h30,32'h66,  1'b0, 1'b1,23'h10,32'h01, 1'b1,23'h10,32'h11,  1'b0,1'b1,32'h44, 4'd7},
    // R5 full; store to 40 dropped
    '{1'b1,23'h40,32'h77,  1'b0, 1'b1,23'h40,32'h12, 1'b1,23'h10,32'h11,  1'b1,1'b0,32'h12, 4'd5},
    // R5 merge while full accepted
    '{1'b1,23'h20,32'h88,  1'b0, 1'b1,23'h30,32'h13, 1'b1,23'h10,32'h11,  1'b1,1'b1,32'h66, 4'd5},
    // R5 merged 88 visible, still full; ack head
    '{1'b0,23'h0,32'h0,    1'b1, 1'b1,23'h20,32'h14, 1'b1,23'h10,32'h11,  1'b1,1'b1,32'h88, 4'd5},
    // R2 next entry shown; R5 dropped store 40 absent
    '{1'b0,23'h0,32'h0,    1'b1, 1'b1,23'h40,32'h15, 1'b1,23'h20,32'h88,  1'b0,1'b0,32'h15, 4'd5},
    // R9 ack and push same cycle
    '{1'b1,23'h50,32'h5A,  1'b1, 1'b1,23'h10,32'h02, 1'b1,23'h10,32'h44,  1'b0,1'b1,32'h44, 4'd9},
    // R3 store to head 30 after wrap: new slot
    '{1'b1,23'h30,32'h67,  1'b0, 1'b0,23'h0,32'h0,   1'b1,23'h30,32'h66,  1'b0,1'b0,32'h0,  4'd3},
    // R7 younger 67 wins over head 66; R3 head unchanged
    '{1'b0,23'h0,32'h0,    1'b1, 1'b1,23'h30,32'h16, 1'b1,23'h30,32'h66,  1'b0,1'b1,32'h67, 4'd7},
    // R9 entry pushed with the ack is next
    '{1'b0,23'h0,32'h0,    1'b1, 1'b0,23'h0,32'h0,   1'b1,23'h50,32'h5A,  1'b0,1'b0,32'h0,  4'd9},
    // R2 last entry
    '{1'b0,23'h0,32'h0,    1'b1, 1'b1,23'h30,32'h03, 1'b1,23'h30,32'h67,  1'b0,1'b1,32'h67, 4'd2},
    // R2 retired entries no longer forward
    '{1'b0,23'h0,32'h0,    1'b0, 1'b1,23'h30,32'h04, 1'b0,23'h0,32'h0,   1'b0,1'b0,32'h04, 4'd2},
    // R1 empty
    '{1'b1,23'h60,32'h61,  1'b0, 1'b0,23'h0,32'h0,   1'b0,23'h0,32'h0,    1'b0,1'b0,32'h0,  4'd1},
    // R6 matching address but strobe low: passthrough
    '{1'b0,23'h0,32'h0,    1'b0, 1'b0,23'h60,32'h70, 1'b1,23'h60,32'h61,  1'b0,1'b0,32'h70, 4'd6},
    // R6 strobe high: forwarded
    '{1'b0,23'h0,32'h0,    1'b1, 1'b1,23'h60,32'h17, 1'b1,23'h60,32'h61,  1'b0,1'b1,32'h61, 4'd6},
    // R1 empty again
    '{1'b0,23'h0,32'h0,    1'b0, 1'b0,23'h0,32'h0,   1'b0,23'h0,32'h0,    1'b0,1'b0,32'h0,  4'd1}
  };

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic sv, input logic [22:0] sa, input logic [31:0] sd,
                       input logic ak, input logic rv, input logic [22:0] ra, input logic [31:0] rd);
    st_valid_i = sv; st_addr_i = sa; st_data_i = sd;
    drain_ack_i = ak; refill_valid_i = rv; refill_addr_i = ra; refill_data_i = rd;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].sv, TBL[i].sa, TBL[i].sd, TBL[i].ak, TBL[i].rv, TBL[i].ra, TBL[i].rd);
      #1;
      chk($sformatf("row %0d drain_valid", i), int'(TBL[i].tag), 32'(drain_valid_o), 32'(TBL[i].edv));
      if (TBL[i].edv) begin
        chk($sformatf("row %0d drain_addr", i), int'(TBL[i].tag), 32'(drain_addr_o), 32'(TBL[i].eda));
        chk($sformatf("row %0d drain_data", i), int'(TBL[i].tag), drain_data_o, TBL[i].edd);
      end
      chk($sformatf("row %0d full", i), int'(TBL[i].tag), 32'(full_o), 32'(TBL[i].efull));
      chk($sformatf("row %0d fill_hit", i), int'(TBL[i].tag), 32'(fill_hit_o), 32'(TBL[i].ehit));
      chk($sformatf("row %0d fill_data", i), int'(TBL[i].tag), fill_data_o, TBL[i].efd);
    end

    // R5 fill four distinct slots, then R1 asynchronous reset clears them
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      drive(1'b1, 23'(23'h100 + i), 32'(32'hB00 + i), 1'b0, 1'b0, 23'h0, 32'h0);
    end
    @(negedge clk);
    drive(1'b0, 23'h0, 32'h0, 1'b0, 1'b1, 23'h103, 32'h0);
    #1;
    chk("full after four stores", 5, 32'(full_o), 32'd1);
    chk("youngest of four forwarded", 6, fill_data_o, 32'hB03);
    #1 rst_ni = 1'b0;
    #1;
    chk("drain_valid in reset", 1, 32'(drain_valid_o), 32'd0);
    chk("full in reset", 1, 32'(full_o), 32'd0);
    chk("no forward in reset", 1, 32'(fill_hit_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 order of draining, with ack held off for one cycle each
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      drive(1'b1, 23'(23'h200 + i), 32'(32'hC00 + i), 1'b0, 1'b0, 23'h0, 32'h0);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      drive(1'b0, 23'h0, 32'h0, 1'b0, 1'b0, 23'h0, 32'h0);
      #1;
      chk($sformatf("held entry %0d addr", i), 2, 32'(drain_addr_o), 32'(23'h200 + i));
      @(negedge clk);
      drive(1'b0, 23'h0, 32'h0, 1'b1, 1'b0, 23'h0, 32'h0);
      #1;
      chk($sformatf("acked entry %0d data", i), 2, drain_data_o, 32'(32'hC00 + i));
    end
    @(negedge clk);
    drive(1'b0, 23'h0, 32'h0, 1'b0, 1'b0, 23'h0, 32'h0);
    #1;
    chk("empty after drain", 2, 32'(drain_valid_o), 32'd0);
    finish_run();
  end
endmodule